// File: doc/BRIEF.md
# Even-Step Two-Digit Display Counter

This block counts through the even values from 0 up to 20 and then starts over at 0. The current value drives two seven-segment digits, one for the tens and one for the units. A clock-enable generator runs on the fast system clock and emits a single-cycle pulse once per programmable period. The count moves on only when that pulse is high, so a person can read the display. With a 4 MHz clock and the default period, the count steps once per second.

The whole block runs on one clock and has one synchronous reset. Each segment bus is active-high. It drives each digit directly, with no scanning. The binary count is also brought out so that the value can be checked directly. The divider period is a parameter, so a test can use a short period.

Top module: `evenDispTop`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets the count to 0, and both segment buses show the zero pattern 0111111.
- R2: The enable pulse occurs once every DIV_TERM+1 clock cycles. The first count change after reset is released happens on the (DIV_TERM+1)-th rising edge. Between changes the count holds its value.
- R3: On each enable, a legal value below 20 goes up by exactly 2. From reset this gives 0, 2, 4, … 18, 20.
- R4: On the enable after the value 20, the count goes to 0. Any odd value, or any value above 20, also goes to 0 on the next enable.
- R5: `tensSeg` shows digit 0 for values 0–8, digit 1 for values 10–18 and digit 2 for 20. A tens digit of 0 is shown, not blanked.
- R6: `unitsSeg` shows the value minus ten times the tens digit.
- R7: Bit 6 down to bit 0 of each segment bus drive segments g, f, e, d, c, b, a. Digits 0–9 use these patterns: 0111111, 0000110, 1011011, 1001111, 1100110, 1101101, 1111101, 0000111, 1111111, 1101111.
- R8: A reset applied mid-run clears the divider as well as the count. The next change then again comes DIV_TERM+1 edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| tensSeg | output | 7 | Tens digit segments, bits g..a, active high |
| unitsSeg | output | 7 | Units digit segments, bits g..a, active high |
| countVal | output | 5 | Current binary count |

## Verification
A wrong divider state shows up at the ports as a change in the count that comes early, comes late or never comes. The bench sees this on the first step after reset, within DIV_TERM+1 cycles. A wrong count or a wrong wrap shows up at once as a bad value on `countVal`, both at the step where it happens and on both segment buses. A wrong digit split or a wrong decode can only show at values that use the faulty digit or pattern. For this reason the sequence is run through two full wraps, so that every tens digit and every even units digit is displayed.

// File: rtl/evenDispPkg.sv
package evenDispPkg;

  typedef struct packed {
    logic tick;
    logic clear;
  } ctlStrobes_t;

  function automatic logic [6:0] segOf(input logic [3:0] digit);
    logic [6:0] pat;
    case (digit)
      4'd0: pat = 7'b0111111;
      4'd1: pat = 7'b0000110;
      4'd2: pat = 7'b1011011;
      4'd3: pat = 7'b1001111;
      4'd4: pat = 7'b1100110;
      4'd5: pat = 7'b1101101;
      4'd6: pat = 7'b1111101;
      4'd7: pat = 7'b0000111;
      4'd8: pat = 7'b1111111;
      4'd9: pat = 7'b1101111;
      default: pat = 7'b0000000;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/evenDispCtl.sv
module evenDispCtl
  import evenDispPkg::*;
#(
  parameter int DIV_TERM = 3999999,
  localparam int DIV_W = (DIV_TERM < 1) ? 1 : $clog2(DIV_TERM + 1)
) (
  input  logic        clk,
  input  logic        rst,
  output ctlStrobes_t strobes
);

  logic [DIV_W-1:0] divCnt;
  logic             atTerm;

  assign atTerm = (divCnt == DIV_W'(DIV_TERM));

  always_ff @(posedge clk) begin
    if (rst || atTerm) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  assign strobes.tick  = atTerm && !rst;
  assign strobes.clear = rst;

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    divCnt <= DIV_W'(DIV_TERM)); // R2
  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    strobes.tick |=> (divCnt == '0)); // R2

endmodule

// File: rtl/evenDispPath.sv
module evenDispPath
  import evenDispPkg::*;
#(
  parameter int MAX_VAL = 20,
  parameter int STEP    = 2,
  localparam int CNT_W  = $clog2(MAX_VAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      strobes,
  output logic [CNT_W-1:0] countQ,
  output logic [6:0]       tensSeg,
  output logic [6:0]       unitsSeg
);

  logic             illegalOrTop;
  logic [CNT_W-1:0] countNext;
  logic [3:0]       tensDig;
  logic [3:0]       unitsDig;

  assign illegalOrTop = countQ[0] || (countQ >= CNT_W'(MAX_VAL));

  always_comb begin
    countNext = countQ;
    if (strobes.tick) countNext = illegalOrTop ? '0 : countQ + CNT_W'(STEP);
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) countQ <= '0;
    else               countQ <= countNext;
  end

  assign tensDig  = 4'(countQ / CNT_W'(10));
  assign unitsDig = 4'(countQ % CNT_W'(10));
  assign tensSeg  = segOf(tensDig);
  assign unitsSeg = segOf(unitsDig);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !strobes.tick |=> $stable(countQ)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (strobes.tick && !illegalOrTop) |=> (countQ == $past(countQ) + CNT_W'(STEP))); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobes.tick && illegalOrTop) |=> (countQ == '0)); // R4
  AST_TENS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (countQ < CNT_W'(10)) |-> (tensSeg == 7'b0111111)); // R5
  AST_ONE_HOT_UNITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((countQ % CNT_W'(10)) == '0) |-> (unitsSeg == 7'b0111111)); // R6

endmodule

// File: rtl/evenDispTop.sv
module evenDispTop
  import evenDispPkg::*;
#(
  parameter int DIV_TERM = 3999999,
  parameter int MAX_VAL  = 20,
  parameter int STEP     = 2,
  localparam int CNT_W   = $clog2(MAX_VAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [6:0]       tensSeg,
  output logic [6:0]       unitsSeg,
  output logic [CNT_W-1:0] countVal
);

  ctlStrobes_t strobes;

  evenDispCtl #(.DIV_TERM(DIV_TERM)) u_ctl (
    .clk(clk), .rst(rst), .strobes(strobes)
  );

  evenDispPath #(.MAX_VAL(MAX_VAL), .STEP(STEP)) u_path (
    .clk(clk), .rst(rst), .strobes(strobes),
    .countQ(countVal), .tensSeg(tensSeg), .unitsSeg(unitsSeg)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (countVal == '0)); // R1

endmodule

// File: tb/evenDispTop_bench.sv
module evenDispTop_bench;

  localparam int DT = 4;

  typedef struct {
    int         val;
    logic [6:0] tens;
    logic [6:0] units;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] tensSeg, unitsSeg;
  logic [4:0] countVal;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  longint edgeNum = 0;
  longint markEdge = 0;
  int prevVal = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  evenDispTop #(.DIV_TERM(DT)) u_evenDispTop (
    .clk(clk), .rst(rst), .tensSeg(tensSeg), .unitsSeg(unitsSeg), .countVal(countVal)
  );

  function automatic logic [6:0] patOf(input int d);
    case (d)
      0: return 7'b0111111;
      1: return 7'b0000110;
      2: return 7'b1011011;
      3: return 7'b1001111;
      4: return 7'b1100110;
      5: return 7'b1101101;
      6: return 7'b1111101;
      7: return 7'b0000111;
      8: return 7'b1111111;
      9: return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushVal(input int v);
    expItem_t it;
    it.val   = v;
    it.tens  = patOf(v / 10);
    it.units = patOf(v % 10);
    expQ.push_back(it);
  endtask

  task automatic doReset(input string req);
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(countVal == 5'd0, req, countVal, 0);
    check(tensSeg == 7'b0111111, req, tensSeg, 7'b0111111);
    check(unitsSeg == 7'b0111111, req, unitsSeg, 7'b0111111);
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic drainQueue();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) edgeNum <= edgeNum + 1;

  // Monitor: pops expected items as the design changes its count
  always @(negedge clk) begin
    if (rst) begin
      markEdge = edgeNum + 1;
      prevVal  = countVal;
    end else if (int'(countVal) != prevVal) begin
      expItem_t it;
      check(edgeNum - markEdge == DT + 1, "R2/R8 step period", edgeNum - markEdge, DT + 1);
      markEdge = edgeNum;
      prevVal  = countVal;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected advance", countVal, -1);
      end else begin
        it = expQ.pop_front();
        if (it.val == 0) check(countVal == 5'd0, "R4 wrap to 0", countVal, 0);
        else             check(int'(countVal) == it.val, "R3 even step", countVal, it.val);
        check(tensSeg == it.tens, "R5 tens digit R7", tensSeg, it.tens);
        check(unitsSeg == it.units, "R6 units digit R7", unitsSeg, it.units);
      end
    end
  end

  initial begin
    doReset("R1 reset state");
    for (int k = 1; k <= 23; k++) pushVal((2 * k) % 22);
    drainQueue();
    doReset("R8 mid-run reset");
    for (int k = 1; k <= 3; k++) pushVal(2 * k);
    drainQueue();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R2 watchdog expired", expQ.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule